// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Timer

This block is a register-mapped watchdog for a system-on-chip. A 32-bit down counter guards the system. A second 32-bit down counter runs beside it and raises an early-warning interrupt. Software loads the warning counter with a smaller value than the watchdog, so the warning fires first and software has time to react.

Each counter advances on a tick from one of two sources. One source is the system clock divided by a power of two, chosen by a 3-bit ratio field. The other is a fixed reference tick from outside the block. When a counter reaches zero it sets a sticky status flag, and that flag drives a level interrupt. The system reset request goes out only when three conditions hold together: the watchdog is running, a separate reset-output enable bit is set, and a separate reset-output mask bit is clear. Software reaches everything through a single-cycle read/write register port.

Top module: `wdog_pretimer`

## Requirements
- R1: After reset, every register reads 0 except the reset-output mask register, which reads 0x0000_0400. The outputs irq_expire, irq_pre and rst_req are low.
- R2: While its enable bit is set, a counter decrements by exactly one on each tick. The watchdog enable is control bit 8 and the warning enable is control bit 2. Control is at offset 0x00.
- R3: Writing a counter register loads the 32-bit value, and reading it returns the current remaining count. The warning counter is at offset 0x1C and the watchdog counter is at offset 0x34. The full value 0xFFFF_FFFF loads and counts down.
- R4: When a counter's enable bit is clear, the counter keeps its value.
- R5: The tick that takes the watchdog from 1 to 0 sets the expired flag (status bit 31) and raises irq_expire. The counter then stays at 0 until it is reloaded, and reloading it does not clear the flag.
- R6: The status flags at offset 0x04 are cleared by writing 0 to their bit. Writing 1 leaves a flag unchanged, and each interrupt follows its own flag.
- R7: rst_req is high only while all of these hold: the expired flag is set, watchdog enable is set, bit 8 of the reset-output enable register (offset 0x40) is set, and bit 10 of the mask register (offset 0x44) is clear.
- R8: When a counter uses the system clock, it ticks once every 2^ratio cycles. The ratio is control bits 18:16.
- R9: Control bit 10 moves the watchdog onto ref_tick, and control bit 12 moves the warning counter onto ref_tick. On that source the ratio has no effect, and each counter chooses its source independently of the other.
- R10: The tick that takes the warning counter from 1 to 0 sets status bit 8 and raises irq_pre. The watchdog keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Fixed reference tick, one clock wide per tick |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_expire | output | 1 | Level interrupt, watchdog expired |
| irq_pre | output | 1 | Level interrupt, early warning |
| rst_req | output | 1 | System reset request |

## Verification
The hardest stimulus to produce is a prescaled count. The phase of the free-running divider is unknown from the ports. The bench therefore waits a whole multiple of the division period, because any window of 32·k cycles holds exactly k ticks. The reference-tick source is driven directly, by holding ref_tick high for a known number of cycles. Reaching the reset-gating combinations requires the expired flag to be set first. The bench then walks the enable and mask registers through each combination while the flag stays sticky.

// File: rtl/wdog_pretimer_pkg.sv
// Shared register offsets, bit positions and the control register layout.
package wdog_pretimer_pkg;
    localparam int unsigned BUS_AW = 8;
    localparam logic [BUS_AW-1:0] OFF_CTRL   = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_STATUS = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_WARN   = 8'h1C;
    localparam logic [BUS_AW-1:0] OFF_WDOG   = 8'h34;
    localparam logic [BUS_AW-1:0] OFF_RSTEN  = 8'h40;
    localparam logic [BUS_AW-1:0] OFF_RSTMSK = 8'h44;

    localparam int unsigned B_WARN_RUN  = 2;
    localparam int unsigned B_WDOG_RUN  = 8;
    localparam int unsigned B_WDOG_REF  = 10;
    localparam int unsigned B_WARN_REF  = 12;
    localparam int unsigned B_RATIO_LO  = 16;
    localparam int unsigned RATIO_BITS  = 3;
    localparam int unsigned B_ST_WARN   = 8;
    localparam int unsigned B_ST_WDOG   = 31;
    localparam int unsigned B_RSTEN     = 8;
    localparam int unsigned B_RSTMSK    = 10;

    // Channel index: 0 = early-warning counter, 1 = watchdog counter
    localparam int unsigned N_CHAN = 2;
    localparam int unsigned CH_WARN = 0;
    localparam int unsigned CH_WDOG = 1;

    typedef struct packed {
        logic [RATIO_BITS-1:0] ratio;
        logic                  warn_ref;
        logic                  wdog_ref;
        logic                  wdog_run;
        logic                  warn_run;
    } ctrl_t;
endpackage

// File: rtl/wdog_pretimer_prescaler.sv
// Power-of-two tick divider.
// Produces a one-cycle tick every 2^ratio clocks from a free-running counter.
// Assumes ratio < 2^RATIO_W; ratio 0 ticks on every cycle.
module wdog_pretimer_prescaler #(
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int unsigned FREE_W = (1 << RATIO_W) - 1;

    logic [FREE_W-1:0] free_q;
    logic [FREE_W-1:0] low_mask;

    // Free-running divider count
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + 1'b1;
    end

    // Mask of the low bits that must all be ones for a tick
    always_comb begin
        for (int i = 0; i < FREE_W; i++) low_mask[i] = (32'(ratio) > i);
    end

    assign tick = &(free_q | ~low_mask);
endmodule

// File: rtl/wdog_pretimer_counter.sv
// Loadable down counter that stops at zero.
// A load wins over a decrement. hit pulses on the tick that takes the count from 1 to 0.
module wdog_pretimer_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic step;
    assign step = run && tick && (count != '0);
    assign hit  = !load && step && (count == CNT_W'(1));

    // Count register: load, else decrement on a live tick
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count - 1'b1;
    end
endmodule

// File: rtl/wdog_pretimer.sv
// Watchdog with early-warning timer, register port and gated reset request.
// Assumes a single-cycle register port: writes take effect at the clock edge and
// reads are combinational. ref_tick is synchronous to clk and one cycle per tick.
module wdog_pretimer
    import wdog_pretimer_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RATIO_W = RATIO_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_expire,
    output logic              irq_pre,
    output logic              rst_req
);
    ctrl_t ctrl_q;
    logic  rsten_q, rstmsk_q;
    logic  flag_warn_q, flag_wdog_q;
    logic  sys_tick;
    logic  wr_ctrl, wr_status, wr_rsten, wr_rstmsk;

    logic [N_CHAN-1:0] ch_run, ch_ref, ch_load, ch_hit;
    logic [CNT_W-1:0]  ch_cnt [N_CHAN];
    logic [CNT_W-1:0]  warn_cnt, wdog_cnt;

    assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
    assign wr_status = bus_sel && bus_wr && (bus_addr == OFF_STATUS);
    assign wr_rsten  = bus_sel && bus_wr && (bus_addr == OFF_RSTEN);
    assign wr_rstmsk = bus_sel && bus_wr && (bus_addr == OFF_RSTMSK);

    assign ch_run[CH_WARN]  = ctrl_q.warn_run;
    assign ch_run[CH_WDOG]  = ctrl_q.wdog_run;
    assign ch_ref[CH_WARN]  = ctrl_q.warn_ref;
    assign ch_ref[CH_WDOG]  = ctrl_q.wdog_ref;
    assign ch_load[CH_WARN] = bus_sel && bus_wr && (bus_addr == OFF_WARN);
    assign ch_load[CH_WDOG] = bus_sel && bus_wr && (bus_addr == OFF_WDOG);

    wdog_pretimer_prescaler #(.RATIO_W(RATIO_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (ctrl_q.ratio),
        .tick  (sys_tick)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : gen_chan
        logic chan_tick;
        assign chan_tick = ch_ref[g] ? ref_tick : sys_tick;
        wdog_pretimer_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ch_run[g]),
            .tick     (chan_tick),
            .load     (ch_load[g]),
            .load_val (bus_wdata[CNT_W-1:0]),
            .count    (ch_cnt[g]),
            .hit      (ch_hit[g])
        );
    end

    assign warn_cnt = ch_cnt[CH_WARN];
    assign wdog_cnt = ch_cnt[CH_WDOG];

    // Control, reset-enable and reset-mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            rsten_q  <= 1'b0;
            rstmsk_q <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.warn_run <= bus_wdata[B_WARN_RUN];
                ctrl_q.wdog_run <= bus_wdata[B_WDOG_RUN];
                ctrl_q.wdog_ref <= bus_wdata[B_WDOG_REF];
                ctrl_q.warn_ref <= bus_wdata[B_WARN_REF];
                ctrl_q.ratio    <= bus_wdata[B_RATIO_LO +: RATIO_W];
            end
            if (wr_rsten)  rsten_q  <= bus_wdata[B_RSTEN];
            if (wr_rstmsk) rstmsk_q <= bus_wdata[B_RSTMSK];
        end
    end

    // Sticky flags: set on a hit, cleared by writing 0 to the bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_warn_q <= 1'b0;
            flag_wdog_q <= 1'b0;
        end else begin
            if (ch_hit[CH_WARN])                        flag_warn_q <= 1'b1;
            else if (wr_status && !bus_wdata[B_ST_WARN]) flag_warn_q <= 1'b0;
            if (ch_hit[CH_WDOG])                        flag_wdog_q <= 1'b1;
            else if (wr_status && !bus_wdata[B_ST_WDOG]) flag_wdog_q <= 1'b0;
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[B_WARN_RUN]             = ctrl_q.warn_run;
                bus_rdata[B_WDOG_RUN]             = ctrl_q.wdog_run;
                bus_rdata[B_WDOG_REF]             = ctrl_q.wdog_ref;
                bus_rdata[B_WARN_REF]             = ctrl_q.warn_ref;
                bus_rdata[B_RATIO_LO +: RATIO_W]  = ctrl_q.ratio;
            end
            OFF_STATUS: begin
                bus_rdata[B_ST_WARN] = flag_warn_q;
                bus_rdata[B_ST_WDOG] = flag_wdog_q;
            end
            OFF_WARN:   bus_rdata[CNT_W-1:0] = warn_cnt;
            OFF_WDOG:   bus_rdata[CNT_W-1:0] = wdog_cnt;
            OFF_RSTEN:  bus_rdata[B_RSTEN]   = rsten_q;
            OFF_RSTMSK: bus_rdata[B_RSTMSK]  = rstmsk_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_expire = flag_wdog_q;
    assign irq_pre    = flag_warn_q;
    assign rst_req    = flag_wdog_q && ctrl_q.wdog_run && rsten_q && !rstmsk_q;
endmodule

// File: rtl/wdog_pretimer_chk.sv
// Property checker for wdog_pretimer, attached with bind.
// Observes ports plus the two counter values and the watchdog run bit.
module wdog_pretimer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_status,
    input logic             clr_bit,
    input logic             wdog_wr,
    input logic             wdog_run,
    input logic [CNT_W-1:0] wdog_cnt,
    input logic [CNT_W-1:0] warn_cnt,
    input logic             irq_expire,
    input logic             irq_pre,
    input logic             rst_req
);
    // R2: without a load, the watchdog moves by at most one per cycle, downward
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wdog_wr) |-> (wdog_cnt == $past(wdog_cnt) || wdog_cnt == $past(wdog_cnt) - 1'b1));

    // R4: a stopped watchdog keeps its value
    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wdog_run) && !$past(wdog_wr)) |-> wdog_cnt == $past(wdog_cnt));

    // R5: a watchdog at zero stays there until reloaded
    assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wdog_cnt) == '0 && !$past(wdog_wr)) |-> wdog_cnt == '0);

    // R6: the expiry interrupt drops only after a clearing status write
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_expire) |-> $past(wr_status && !clr_bit));

    // R7: a reset request needs an expired, running watchdog
    assert_rst_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (irq_expire && wdog_run));

    // R10: the warning interrupt rises only with the warning counter at zero
    assert_warn_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pre) |-> warn_cnt == '0);
endmodule

bind wdog_pretimer wdog_pretimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_status  (wr_status),
    .clr_bit    (bus_wdata[31]),
    .wdog_wr    (ch_load[1]),
    .wdog_run   (ctrl_q.wdog_run),
    .wdog_cnt   (wdog_cnt),
    .warn_cnt   (warn_cnt),
    .irq_expire (irq_expire),
    .irq_pre    (irq_pre),
    .rst_req    (rst_req)
);

// File: tb/wdog_pretimer_tb.sv
`timescale 1ns/1ps
module wdog_pretimer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_expire, irq_pre, rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] rd;

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_WARN = 8'h1C,
                           A_WDOG = 8'h34, A_RSTEN = 8'h40, A_RSTMSK = 8'h44;

    wdog_pretimer u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_expire(irq_expire), .irq_pre(irq_pre), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_reset();
        rdreg(A_CTRL, rd);   check("R1", "ctrl", rd, 32'h0);
        rdreg(A_STAT, rd);   check("R1", "status", rd, 32'h0);
        rdreg(A_WDOG, rd);   check("R1", "wdog count", rd, 32'h0);
        rdreg(A_RSTMSK, rd); check("R1", "mask", rd, 32'h0000_0400);
        check("R1", "outputs", {29'h0, irq_expire, irq_pre, rst_req}, 32'h0);
    endtask

    task automatic t_count_and_stop();
        logic [31:0] held;
        quiesce();
        wr(A_WDOG, 32'd10);
        wr(A_CTRL, 32'h0000_0100);
        repeat (4) @(posedge clk);
        rdreg(A_WDOG, rd); check("R2", "count after 4 ticks", rd, 32'd6);
        wr(A_CTRL, 32'h0);
        rdreg(A_WDOG, held);
        repeat (5) @(posedge clk);
        rdreg(A_WDOG, rd); check("R4", "stopped count held", rd, held);
    endtask

    task automatic t_expire();
        quiesce();
        wr(A_WDOG, 32'd3);
        wr(A_CTRL, 32'h0000_0100);
        repeat (2) @(posedge clk);
        #1 check("R5", "irq before zero", {31'h0, irq_expire}, 32'h0);
        @(posedge clk);
        rdreg(A_WDOG, rd); check("R5", "count at zero", rd, 32'h0);
        check("R5", "irq_expire at zero", {31'h0, irq_expire}, 32'h1);
        repeat (5) @(posedge clk);
        rdreg(A_WDOG, rd); check("R5", "count holds zero", rd, 32'h0);
        wr(A_WDOG, 32'd50);
        rdreg(A_STAT, rd); check("R5", "flag survives reload", rd, 32'h8000_0000);
    endtask

    task automatic t_clear();
        quiesce();
        wr(A_WARN, 32'd1);
        wr(A_WDOG, 32'd1);
        wr(A_CTRL, 32'h0000_0104);
        @(posedge clk);
        rdreg(A_STAT, rd); check("R6", "both flags", rd, 32'h8000_0100);
        wr(A_STAT, 32'h0000_0100);
        rdreg(A_STAT, rd); check("R6", "clear expired only", rd, 32'h0000_0100);
        check("R6", "irqs follow flags", {30'h0, irq_expire, irq_pre}, 32'h1);
        wr(A_STAT, 32'h8000_0000);
        rdreg(A_STAT, rd); check("R6", "clear warning", rd, 32'h0);
    endtask

    task automatic t_gating();
        quiesce();
        wr(A_RSTEN, 32'h0000_0100);
        wr(A_RSTMSK, 32'h0);
        wr(A_WDOG, 32'd2);
        wr(A_CTRL, 32'h0000_0100);
        repeat (2) @(posedge clk);
        #1 check("R7", "all gates open", {31'h0, rst_req}, 32'h1);
        wr(A_RSTMSK, 32'h0000_0400);
        #1 check("R7", "masked", {31'h0, rst_req}, 32'h0);
        wr(A_RSTMSK, 32'h0);
        #1 check("R7", "unmasked again", {31'h0, rst_req}, 32'h1);
        wr(A_RSTEN, 32'h0);
        #1 check("R7", "enable bit clear", {31'h0, rst_req}, 32'h0);
        wr(A_RSTEN, 32'h0000_0100);
        wr(A_CTRL, 32'h0);
        #1 check("R7", "watchdog stopped", {31'h0, rst_req}, 32'h0);
        wr(A_RSTMSK, 32'h0000_0400);
    endtask

    task automatic t_prescale();
        quiesce();
        wr(A_WDOG, 32'd100);
        wr(A_CTRL, 32'h0005_0100);
        repeat (64) @(posedge clk);
        rdreg(A_WDOG, rd); check("R8", "ratio 5 over 64 cycles", rd, 32'd98);
    endtask

    task automatic t_ref();
        quiesce();
        wr(A_WDOG, 32'd50);
        wr(A_CTRL, 32'h0005_0500);
        repeat (10) @(posedge clk);
        rdreg(A_WDOG, rd); check("R9", "no ref ticks", rd, 32'd50);
        @(negedge clk); ref_tick = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); ref_tick = 1'b0;
        rdreg(A_WDOG, rd); check("R9", "three ref ticks", rd, 32'd47);
        quiesce();
        wr(A_WARN, 32'd30);
        wr(A_WDOG, 32'd30);
        wr(A_CTRL, 32'h0000_1104);
        repeat (5) @(posedge clk);
        rdreg(A_WARN, rd); check("R9", "warning on ref held", rd, 32'd30);
        rdreg(A_WDOG, rd); check("R9", "watchdog on sys clock", rd, 32'd24);
    endtask

    task automatic t_warning();
        quiesce();
        wr(A_WARN, 32'd4);
        wr(A_WDOG, 32'd20);
        wr(A_CTRL, 32'h0000_0104);
        repeat (4) @(posedge clk);
        rdreg(A_WDOG, rd); check("R10", "watchdog still counting", rd, 32'd16);
        check("R10", "irq_pre high, irq_expire low", {30'h0, irq_pre, irq_expire}, 32'h2);
        rdreg(A_STAT, rd); check("R10", "warning flag", rd, 32'h0000_0100);
    endtask

    task automatic t_maxload();
        quiesce();
        wr(A_WDOG, 32'hFFFF_FFFF);
        rdreg(A_WDOG, rd); check("R3", "max load readback", rd, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0000_0100);
        @(posedge clk);
        rdreg(A_WDOG, rd); check("R3", "max load decrements", rd, 32'hFFFF_FFFE);
        quiesce();
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_count_and_stop();
        t_expire();
        t_clear();
        t_gating();
        t_prescale();
        t_ref();
        t_warning();
        t_maxload();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule